// File: doc/BRIEF.md
# I2C Register-File Target with Byte-Level Clock Stretching

This block is an I2C target that serves a small register memory of its own. It samples the bus clock and data lines through a synchroniser and recognises START, repeated START and STOP. It acknowledges only its fixed 7-bit device address. Both lines are driven as open-drain enables: a high enable pulls the wire low, and a low enable releases it. A write transfer puts its first data byte into an internal pointer, and every later byte in that transfer goes to the location the pointer names. A read transfer returns bytes from the pointer location. The pointer steps forward after every data byte and wraps at the end of memory. A write that sets the pointer, followed by a repeated START into a read, therefore reads from the chosen location.

After every byte that ends in an acknowledge, the target holds SCL low. It keeps holding until the internal side raises `ready`. This gives the internal logic as much time as it needs between bytes. The internal side also sees each stored byte through a one-cycle write strobe with its address and data.

Top module: `i2c_regfile_target`

## Requirements
- R1: While reset is applied and in the first cycle after it, `sda_oe`, `scl_oe` and `wr_stb` are all 0.
- R2: The first byte after a START holds the address and then the direction bit, sent most significant bit first. Direction 0 means write and 1 means read. When the 7 address bits equal `DEV_ADDR`, the target pulls SDA low during the ninth clock (ACK). For any other address, it leaves SDA released (NACK) and ignores all following bytes until the next START.
- R3: In a write transfer, the first data byte is acknowledged and its low `AW` bits load the pointer. This byte produces no write strobe and stores nothing.
- R4: Every later byte in a write transfer is acknowledged and stored at the pointer. At the same time `wr_stb` is high for exactly one cycle, with `wr_addr` equal to the pointer and `wr_data` equal to the byte. The pointer then advances by one.
- R5: In a read transfer, each byte is driven most significant bit first and comes from the memory location the pointer names. The pointer advances after each byte. A read that follows a repeated START continues from the pointer value that the preceding write left.
- R6: The pointer wraps from location 2^AW-1 to location 0, for both writes and reads.
- R7: After the acknowledge clock of an acknowledged byte, the target holds SCL low (`scl_oe`=1). This applies to the address byte, to write data bytes, and to read bytes that the controller acknowledged. The hold lasts while `ready` is 0, and SCL is released within a few cycles once `ready` is 1.
- R8: If the controller answers a read byte with NACK, the target releases SDA and SCL. It drives neither line until a STOP or a START.
- R9: A START or repeated START always returns the target to address reception, even in the middle of a byte. A partly received byte is dropped without being stored.
- R10: A STOP that follows a START with no address byte between them returns the target to idle. It writes nothing and leaves the pointer unchanged.
- R11: The target changes its SDA enable only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Level of the SCL wire |
| sda_i | input | 1 | Level of the SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or data 0) |
| ready | input | 1 | Internal side ready; releases a held SCL |
| wr_stb | output | 1 | One-cycle pulse per stored byte |
| wr_addr | output | AW | Location of the stored byte |
| wr_data | output | 8 | Value of the stored byte |

## Verification
The bench builds the block with its default parameters: `AW` = 4 (16 locations), a two-stage synchroniser and device address 0x2A. With only 16 locations, a pointer of 0x0F reaches the wrap from the last location to location 0 within a two-byte burst, in both writes and reads. The default address lets the bench run matching transfers and a mismatching address 0x33 in the same session. Short bit times at the bench's clock keep the `ready`-held stretch, the repeated START inside a byte and the START-then-STOP case all within the run length.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK,
    ST_HOLD,
    ST_LAUNCH,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
module i2c_tgt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk) begin
      if (rst) ff <= '1;
      else     ff <= {ff[STAGES-2:0], d[g]};
    end
    assign q[g] = ff[STAGES-1];
  end
endmodule

// File: rtl/i2c_tgt_cond.sv
`timescale 1ns/1ps
module i2c_tgt_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p,
  output logic scl_lvl,
  output logic sda_lvl
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_p  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_p   = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_lvl  = scl_s;
  assign sda_lvl  = sda_s;
endmodule

// File: rtl/i2c_tgt_regmem.sv
`timescale 1ns/1ps
module i2c_tgt_regmem #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_tgt_engine.sv
`timescale 1ns/1ps
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int         AW       = 4,
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              sda_lvl,
  input  logic              ready,
  input  logic [BYTE_W-1:0] rd_q,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              wr_stb,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [AW-1:0]     ptr,
  output tgt_state_e        st
);
  tgt_state_e        nxt;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh;
  logic              first_wr;
  logic              rw;
  logic              m_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      nxt      <= ST_WR;
      cnt      <= '0;
      sh       <= '0;
      first_wr <= 1'b0;
      rw       <= 1'b0;
      m_ack    <= 1'b0;
      sda_oe   <= 1'b0;
      scl_oe   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      ptr      <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_p) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else if (stop_p) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                st     <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              sda_oe   <= 1'b0;
              scl_oe   <= 1'b1;
              cnt      <= '0;
              first_wr <= ~rw;
              nxt      <= rw ? ST_RD : ST_WR;
              st       <= ST_HOLD;
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              sda_oe <= 1'b1;
              st     <= ST_WACK;
              if (first_wr) begin
                ptr      <= sh[AW-1:0];
                first_wr <= 1'b0;
              end else begin
                wr_stb  <= 1'b1;
                wr_addr <= ptr;
                wr_data <= sh;
                ptr     <= ptr + 1'b1;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              scl_oe <= 1'b1;
              cnt    <= '0;
              nxt    <= ST_WR;
              st     <= ST_HOLD;
            end
          end
          ST_HOLD: begin
            if (ready) begin
              if (nxt == ST_RD) begin
                sh     <= rd_q;
                sda_oe <= ~rd_q[BYTE_W-1];
              end
              st <= ST_LAUNCH;
            end
          end
          ST_LAUNCH: begin
            scl_oe <= 1'b0;
            st     <= nxt;
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
                st     <= ST_RACK;
              end else begin
                sh     <= {sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~sh[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (m_ack) begin
                scl_oe <= 1'b1;
                cnt    <= '0;
                nxt    <= ST_RD;
                st     <= ST_HOLD;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regfile_target.sv
`timescale 1ns/1ps
module i2c_regfile_target
  import i2c_tgt_pkg::*;
#(
  parameter int         AW          = 4,
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              ready,
  output logic              wr_stb,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, start_p, stop_p, scl_lvl, sda_lvl;
  logic [AW-1:0]     ptr;
  logic [BYTE_W-1:0] rd_q;
  tgt_state_e        st;

  i2c_tgt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   ({scl_s, sda_s})
  );

  i2c_tgt_cond u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl)
  );

  i2c_tgt_engine #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .sda_lvl  (sda_lvl),
    .ready    (ready),
    .rd_q     (rd_q),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_oe),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ptr      (ptr),
    .st       (st)
  );

  i2c_tgt_regmem #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk   (clk),
    .we    (wr_stb),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (ptr),
    .rdata (rd_q)
  );
endmodule

// File: rtl/i2c_tgt_checker.sv
`timescale 1ns/1ps
module i2c_tgt_checker
  import i2c_tgt_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       ready,
  input logic       wr_stb,
  input logic       start_p,
  input logic       stop_p,
  input logic       scl_lvl,
  input tgt_state_e st
);
  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!sda_oe && !scl_oe && !wr_stb)); // R1
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst) !$stable(sda_oe) |-> (!$past(scl_lvl) || $past(scl_oe))); // R11
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst) (st == ST_HOLD && !ready) |=> scl_oe); // R7
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) wr_stb |=> !wr_stb); // R4
  AST_START_REARMS: assert property (@(posedge clk) disable iff (rst) start_p |=> (st == ST_ADDR)); // R9
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst) (stop_p && !start_p) |=> (st == ST_IDLE && !sda_oe && !scl_oe)); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst) (st == ST_IDLE) |-> (!sda_oe && !scl_oe)); // R2
  AST_NACK_SILENT: assert property (@(posedge clk) disable iff (rst) (st == ST_WAIT) |-> (!sda_oe && !scl_oe)); // R8
endmodule

bind i2c_regfile_target i2c_tgt_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .sda_oe  (sda_oe),
  .scl_oe  (scl_oe),
  .ready   (ready),
  .wr_stb  (wr_stb),
  .start_p (start_p),
  .stop_p  (stop_p),
  .scl_lvl (scl_lvl),
  .st      (st)
);

// File: tb/sim_i2c_regfile_target.sv
`timescale 1ns/1ps
module sim_i2c_regfile_target;
  localparam int Q = 25;
  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic ready = 1'b1;
  logic scl_oe, sda_oe, wr_stb;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  wire scl_line = scl_m & ~scl_oe;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  int viol = 0;
  bit done = 1'b0;
  logic [11:0] exp_wr[$];
  logic [7:0]  exp_rd[$];

  always #2.5 clk = ~clk;

  i2c_regfile_target u0 (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .ready(ready),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for stored bytes (R4, R6)
  always @(negedge clk) begin
    if (!rst && wr_stb) begin
      if (exp_wr.size() == 0) chk(1'b0, "R4 unexpected write", {wr_addr, wr_data}, 0);
      else begin
        logic [11:0] e;
        e = exp_wr.pop_front();
        chk({wr_addr, wr_data} == e, "R4 write strobe", {wr_addr, wr_data}, e);
      end
    end
  end

  // R11 monitor: SDA enable must not move while the wire SCL stays high
  logic oe_q = 1'b0;
  logic scl_q = 1'b1;
  always @(negedge clk) begin
    if (!rst && sda_oe != oe_q && scl_q && scl_line) viol++;
    oe_q  <= sda_oe;
    scl_q <= scl_line;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    while (!scl_line) @(posedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; cyc(Q);
    scl_up(); cyc(Q);
    sda_m = 1'b0; cyc(Q);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; cyc(Q);
    scl_up(); cyc(Q);
    sda_m = 1'b1; cyc(2*Q);
  endtask

  task automatic wbit(input bit b);
    sda_m = b; cyc(Q);
    scl_up(); cyc(2*Q);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic rbit(output bit b);
    sda_m = 1'b1; cyc(Q);
    scl_up(); cyc(Q);
    b = sda_line; cyc(Q);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic wbyte(input logic [7:0] v, output bit nack);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(nack);
  endtask

  task automatic rbyte(input bit nack, output logic [7:0] v);
    bit b;
    for (int i = 0; i < 8; i++) begin
      rbit(b);
      v = {v[6:0], b};
    end
    wbit(nack);
  endtask

  // driver helpers
  task automatic send_ack(input logic [7:0] v, input bit exp_nack, input string req);
    bit n;
    wbyte(v, n);
    chk(n == exp_nack, req, n, exp_nack);
  endtask

  task automatic put_byte(input logic [3:0] a, input logic [7:0] v);
    exp_wr.push_back({a, v});
    send_ack(v, 1'b0, "R4 data ack");
  endtask

  task automatic get_byte(input logic [7:0] v, input bit nack, input string req);
    logic [7:0] got;
    logic [7:0] e;
    exp_rd.push_back(v);
    rbyte(nack, got);
    e = exp_rd.pop_front();
    chk(got == e, req, got, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit b;
    cyc(5);
    @(negedge clk);
    chk(!sda_oe && !scl_oe && !wr_stb, "R1 reset outputs", {sda_oe, scl_oe, wr_stb}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!sda_oe && !scl_oe && !wr_stb, "R1 after reset", {sda_oe, scl_oe, wr_stb}, 0);
    cyc(20);

    // R3/R4: pointer then three stored bytes
    start_c();
    send_ack({DEV, 1'b0}, 1'b0, "R2 address ack");
    send_ack(8'h03, 1'b0, "R3 pointer ack");
    put_byte(4'h3, 8'hA1);
    put_byte(4'h4, 8'hB2);
    put_byte(4'h5, 8'hC3);
    stop_c();

    // R5/R8: combined format, read continues from pointer
    start_c();
    send_ack({DEV, 1'b0}, 1'b0, "R2 address ack");
    send_ack(8'h04, 1'b0, "R3 pointer ack");
    start_c();
    send_ack({DEV, 1'b1}, 1'b0, "R5 read address ack");
    get_byte(8'hB2, 1'b0, "R5 read first");
    get_byte(8'hC3, 1'b1, "R5 read second");
    chk(!sda_oe && !scl_oe, "R8 released after nack", {sda_oe, scl_oe}, 0);
    rbit(b);
    chk(b == 1'b1, "R8 no drive after nack", b, 1);
    stop_c();

    // R6: wrap in write and read
    start_c();
    send_ack({DEV, 1'b0}, 1'b0, "R2 address ack");
    send_ack(8'h0F, 1'b0, "R3 pointer ack");
    put_byte(4'hF, 8'h5A);
    put_byte(4'h0, 8'h6B);
    stop_c();
    start_c();
    send_ack({DEV, 1'b0}, 1'b0, "R2 address ack");
    send_ack(8'h0F, 1'b0, "R3 pointer ack");
    start_c();
    send_ack({DEV, 1'b1}, 1'b0, "R6 read address ack");
    get_byte(8'h5A, 1'b0, "R6 read last location");
    get_byte(8'h6B, 1'b1, "R6 read wrapped location");
    stop_c();

    // R2: foreign address is refused and ignored
    start_c();
    send_ack({7'h33, 1'b0}, 1'b1, "R2 foreign address nack");
    send_ack(8'h05, 1'b1, "R2 ignored byte nack");
    send_ack(8'h99, 1'b1, "R2 ignored byte nack");
    stop_c();
    start_c();
    send_ack({DEV, 1'b0}, 1'b0, "R2 address ack");
    send_ack(8'h05, 1'b0, "R3 pointer ack");
    start_c();
    send_ack({DEV, 1'b1}, 1'b0, "R2 read address ack");
    get_byte(8'hC3, 1'b1, "R2 memory untouched");
    stop_c();

    // R10: START then STOP leaves pointer alone
    start_c();
    send_ack({DEV, 1'b0}, 1'b0, "R2 address ack");
    send_ack(8'h04, 1'b0, "R3 pointer ack");
    stop_c();
    start_c();
    stop_c();
    chk(!sda_oe && !scl_oe, "R10 idle after start-stop", {sda_oe, scl_oe}, 0);
    start_c();
    send_ack({DEV, 1'b1}, 1'b0, "R10 read address ack");
    get_byte(8'hB2, 1'b1, "R10 pointer unchanged");
    stop_c();

    // R9: repeated START in the middle of a data byte
    start_c();
    send_ack({DEV, 1'b0}, 1'b0, "R2 address ack");
    send_ack(8'h04, 1'b0, "R3 pointer ack");
    wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b1);
    start_c();
    send_ack({DEV, 1'b1}, 1'b0, "R9 address after restart");
    get_byte(8'hB2, 1'b1, "R9 partial byte dropped");
    stop_c();

    // R7: stretch held while ready is low
    ready = 1'b0;
    start_c();
    send_ack({DEV, 1'b0}, 1'b0, "R2 address ack");
    sda_m = 1'b0; cyc(Q);
    scl_m = 1'b1; cyc(200);
    chk(scl_line == 1'b0 && scl_oe == 1'b1, "R7 SCL held", {scl_line, scl_oe}, 2'b01);
    ready = 1'b1;
    cyc(10);
    chk(scl_line == 1'b1, "R7 SCL released on ready", scl_line, 1);
    scl_up(); cyc(Q);
    sda_m = 1'b1; cyc(2*Q);

    cyc(20);
    chk(exp_wr.size() == 0, "R4 all writes seen", exp_wr.size(), 0);
    chk(viol == 0, "R11 SDA moved with SCL high", viol, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule